// File: doc/BRIEF.md
# Triggered Multi-Buffer Serial Transfer Sequencer

This block keeps a small bank of word buffers. Each buffer holds a word to send, a word received back, and three control bits. When software raises a trigger, the block sends a run of neighbouring buffers out through a built-in mode-0 serial master. The run begins at a chosen first buffer and covers a chosen number of buffers. Each received word is stored in the receive field of the buffer it came from. When the whole run has gone out, a sticky done flag is raised.

Every trigger starts exactly one pass. A trigger that comes while a pass is running is dropped. Between buffers the select line is either kept low, so the next word goes out straight away, or released for a short or a long gap. A lock bit protects a buffer's contents against software writes while a pass is running.

Top module: `spi_mbuf_seq`

## Requirements
- R1: A trigger sampled while idle, with `cfg_len` not zero, starts exactly one pass. `busy` is high from the next cycle until the pass ends.
- R2: A trigger sampled while `busy` is high is ignored. The running pass, its buffer order and its timing are not changed.
- R3: A pass sends buffers `cfg_start`, `cfg_start+1`, and so on, `cfg_len` of them. The index wraps from NBUF-1 to 0. Start 0 with length 4 sends buffers 0, 1, 2, 3.
- R4: Frame timing. A frame that follows a release begins with HALF cycles of select low and clock low. Then come W bits, MSB first, each with HALF cycles of clock low and then HALF cycles of clock high. `spi_mosi` changes only while the clock is low, and `spi_miso` is sampled at the rising edge. HALF cycles with select low and clock low close the frame. The clock is never high while select is high.
- R5: If the hold bit (bit 2 of the control write) is set on a buffer that is not the last of the pass, the next buffer's first bit follows its hold phase at once. Select stays low and there is no setup phase.
- R6: If the hold bit is clear, or the buffer is the last of the pass, select goes high after the hold phase. It stays high for GAP cycles when the delay bit (bit 0) is set, and for 1 cycle otherwise. The last buffer always releases, even when its hold bit is set.
- R7: Each received word is written into the receive field of its own buffer. It can be read through `rd_idx`/`rd_data` once the frame's hold phase has ended.
- R8: `done` rises in the same cycle that `busy` falls at the end of a pass. It is cleared by the next accepted trigger and otherwise holds its value.
- R9: A trigger with `cfg_len` equal to zero does nothing. `busy` stays low and `done` keeps its value.
- R10: Every accepted trigger sends the group again, even if no buffer has been rewritten. A buffer's word and control bits are taken from the values stored at the edge where its frame is loaded, so rewrites made between passes take effect.
- R11: A software write is discarded if `busy` is high and the stored lock bit (bit 1) of the target buffer is set. All other writes are accepted.
- R12: After reset, select is high, the clock is low, `busy` and `done` are low, and every receive field reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Software trigger, sampled each cycle |
| cfg_start | input | IW | First buffer of the group |
| cfg_len | input | LW | Number of buffers in the group |
| wr_en | input | 1 | Buffer write strobe |
| wr_idx | input | IW | Buffer written |
| wr_data | input | W | Word to send |
| wr_ctrl | input | 3 | Control bits {hold, lock, delay} |
| rd_idx | input | IW | Buffer whose received word is read |
| rd_data | output | W | Received word of buffer `rd_idx` |
| busy | output | 1 | A pass is running |
| done | output | 1 | Sticky pass-complete flag |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low select |

## Verification
Two events can fall in the same cycle: the final gap cycle of a pass and a trigger. The trigger must be dropped, because the pass is still running. The bench provokes this by holding the trigger high across a whole pass and past its end. The reference model then expects `done` to be high for exactly one idle cycle, followed by a fresh pass with `done` cleared. A buffer write landing in the middle of a pass is the second collision. It is judged by whether later frames carry the old or the new word, according to the lock bit.

// File: rtl/spi_mbuf_pkg.sv
package spi_mbuf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } seq_state_t;

  typedef struct packed {
    logic hold;
    logic lock;
    logic dly;
  } buf_ctrl_t;

endpackage

// File: rtl/spi_mbuf_store.sv
module spi_mbuf_store
  import spi_mbuf_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int W    = 16,
  localparam int IW  = $clog2(NBUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  buf_ctrl_t     wr_ctrl,
  input  logic [IW-1:0] tx_idx,
  output logic [W-1:0]  tx_data,
  output logic          tx_hold,
  output logic          tx_dly,
  input  logic          rx_we,
  input  logic [IW-1:0] rx_idx,
  input  logic [W-1:0]  rx_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] tx_q   [NBUF];
  buf_ctrl_t    ctrl_q [NBUF];
  logic [W-1:0] rx_q   [NBUF];
  logic         wr_ok;

  // write enable: a locked buffer refuses software writes during a pass
  assign wr_ok = wr_en && !(busy && ctrl_q[wr_idx].lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) begin
        tx_q[i]   <= '0;
        ctrl_q[i] <= '0;
        rx_q[i]   <= '0;
      end
    end else begin
      if (wr_ok) begin
        tx_q[wr_idx]   <= wr_data;
        ctrl_q[wr_idx] <= wr_ctrl;
      end
      if (rx_we) begin
        rx_q[rx_idx] <= rx_data;
      end
    end
  end

  assign tx_data = tx_q[tx_idx];
  assign tx_hold = ctrl_q[tx_idx].hold;
  assign tx_dly  = ctrl_q[tx_idx].dly;
  assign rd_data = rx_q[rd_idx];

  for (genvar i = 0; i < NBUF; i++) begin : g_lock_chk
    // R11: a blocked write leaves the entry untouched
    p_lock_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy && wr_idx == IW'(i) && ctrl_q[i].lock) |=> $stable(tx_q[i]));
  end

endmodule

// File: rtl/spi_mbuf_shift.sv
module spi_mbuf_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_en,
  input  logic         sample_en,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);

  logic [W-1:0] tx_q, tx_n;
  logic [W-1:0] rx_q, rx_n;

  always_comb begin
    tx_n = tx_q;
    rx_n = rx_q;
    if (load) begin
      tx_n = load_data;
    end else if (shift_en) begin
      tx_n = {tx_q[W-2:0], 1'b0};
    end
    if (sample_en) begin
      rx_n = {rx_q[W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_n;
      rx_q <= rx_n;
    end
  end

  assign mosi    = tx_q[W-1];
  assign rx_word = rx_q;

endmodule

// File: rtl/spi_mbuf_seq.sv
module spi_mbuf_seq
  import spi_mbuf_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int W    = 16,
  parameter int HALF = 2,
  parameter int GAP  = 4,
  localparam int IW   = $clog2(NBUF),
  localparam int LW   = $clog2(NBUF + 1),
  localparam int BW   = $clog2(W),
  localparam int TMAX = (2 * HALF > GAP) ? 2 * HALF : GAP,
  localparam int TW   = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [IW-1:0] cfg_start,
  input  logic [LW-1:0] cfg_len,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [2:0]    wr_ctrl,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          busy,
  output logic          done,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs_n
);

  seq_state_t    state_q, state_n;
  logic [TW-1:0] tick_q, tick_n, gap_last;
  logic [BW-1:0] bit_q, bit_n;
  logic [IW-1:0] ptr_q, ptr_n, ptr_inc, load_idx;
  logic [LW-1:0] rem_q, rem_n;
  logic          hold_q, hold_n, dly_q, dly_n, done_q, done_n;
  logic          load, shift_en, sample_en, rx_we;
  logic [W-1:0]  tx_data, rx_word;
  logic          tx_hold, tx_dly;
  buf_ctrl_t     wr_ctrl_s;

  assign wr_ctrl_s = buf_ctrl_t'(wr_ctrl);
  assign ptr_inc   = (ptr_q == IW'(NBUF - 1)) ? '0 : ptr_q + 1'b1;
  assign gap_last  = dly_q ? TW'(GAP - 1) : '0;

  spi_mbuf_store #(.NBUF(NBUF), .W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ctrl(wr_ctrl_s),
    .tx_idx(load_idx), .tx_data(tx_data), .tx_hold(tx_hold), .tx_dly(tx_dly),
    .rx_we(rx_we), .rx_idx(ptr_q), .rx_data(rx_word),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  spi_mbuf_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(tx_data),
    .shift_en(shift_en), .sample_en(sample_en), .miso(spi_miso),
    .mosi(spi_mosi), .rx_word(rx_word)
  );

  always_comb begin
    state_n   = state_q;
    tick_n    = tick_q;
    bit_n     = bit_q;
    ptr_n     = ptr_q;
    rem_n     = rem_q;
    done_n    = done_q;
    load      = 1'b0;
    load_idx  = ptr_q;
    shift_en  = 1'b0;
    sample_en = 1'b0;
    rx_we     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig && cfg_len != '0) begin
          state_n  = ST_SETUP;
          tick_n   = '0;
          ptr_n    = cfg_start;
          rem_n    = cfg_len;
          done_n   = 1'b0;
          load     = 1'b1;
          load_idx = cfg_start;
        end
      end
      ST_SETUP: begin
        if (tick_q == TW'(HALF - 1)) begin
          state_n = ST_SHIFT;
          tick_n  = '0;
          bit_n   = '0;
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        sample_en = (tick_q == TW'(HALF - 1));
        if (tick_q == TW'(2 * HALF - 1)) begin
          shift_en = 1'b1;
          tick_n   = '0;
          if (bit_q == BW'(W - 1)) begin
            state_n = ST_HOLD;
            bit_n   = '0;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (tick_q == TW'(HALF - 1)) begin
          rx_we  = 1'b1;
          tick_n = '0;
          if (rem_q != LW'(1) && hold_q) begin
            state_n  = ST_SHIFT;
            bit_n    = '0;
            ptr_n    = ptr_inc;
            rem_n    = rem_q - 1'b1;
            load     = 1'b1;
            load_idx = ptr_inc;
          end else begin
            state_n = ST_GAP;
          end
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (tick_q == gap_last) begin
          tick_n = '0;
          if (rem_q == LW'(1)) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n  = ST_SETUP;
            ptr_n    = ptr_inc;
            rem_n    = rem_q - 1'b1;
            load     = 1'b1;
            load_idx = ptr_inc;
          end
        end else begin
          tick_n = tick_q + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    hold_n = load ? tx_hold : hold_q;
    dly_n  = load ? tx_dly  : dly_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      bit_q   <= '0;
      ptr_q   <= '0;
      rem_q   <= '0;
      hold_q  <= 1'b0;
      dly_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      tick_q  <= tick_n;
      bit_q   <= bit_n;
      ptr_q   <= ptr_n;
      rem_q   <= rem_n;
      hold_q  <= hold_n;
      dly_q   <= dly_n;
      done_q  <= done_n;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign spi_cs_n = !(state_q == ST_SETUP || state_q == ST_SHIFT || state_q == ST_HOLD);
  assign spi_sclk = (state_q == ST_SHIFT) && (tick_q >= TW'(HALF));

  // R1: an accepted trigger starts a pass and clears done
  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && cfg_len != '0) |=> (busy && !done));
  // R9: zero length leaves the block idle and done untouched
  p_len_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig && cfg_len == '0) |=> (!busy && $stable(done)));
  // R4: clock only toggles while the slave is selected
  p_sclk_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !spi_cs_n);
  // R8: done rises exactly when busy falls
  p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($fell(busy)));
  // R6: select goes high only from the hold phase of a frame
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(state_q == ST_HOLD));

endmodule

// File: tb/sim_spi_mbuf_seq.sv
module sim_spi_mbuf_seq;
  localparam int CLK_NS = 10;
  localparam int NB = 8;
  localparam int WD = 16;
  localparam int H  = 2;
  localparam int G  = 4;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic mosi;
    logic mcare;
    logic busy;
    logic done;
  } rec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic [2:0]    cfg_start = '0;
  logic [3:0]    cfg_len = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_idx = '0;
  logic [15:0]   wr_data = '0;
  logic [2:0]    wr_ctrl = '0;
  logic [2:0]    rd_idx = '0;
  logic [15:0]   rd_data;
  logic          busy, done, spi_sclk, spi_mosi, spi_cs_n;
  logic          spi_miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [15:0] m_tx [NB];
  logic        m_hold [NB];
  logic        m_lock [NB];
  logic        m_dly [NB];
  logic [15:0] m_rx [NB];
  int          m_fno = 0;
  logic        m_done = 1'b0;
  rec_t        q[$];
  rec_t        cur;

  spi_mbuf_seq #(.NBUF(NB), .W(WD), .HALF(H), .GAP(G)) u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_start(cfg_start), .cfg_len(cfg_len),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [15:0] slave_word(int n);
    return 16'((n * 937) ^ 16'hB16D);
  endfunction

  // slave: next bit presented after each rising serial clock
  initial begin
    int rcnt = 0;
    int fno = 0;
    logic [15:0] w;
    w = slave_word(0);
    spi_miso = w[15];
    forever begin
      @(posedge spi_sclk);
      rcnt++;
      if (rcnt == WD) begin
        rcnt = 0;
        fno++;
      end
      w = slave_word(fno);
      spi_miso = w[15 - rcnt];
    end
  end

  task automatic push(logic cs, logic sk, logic mo, logic mc);
    rec_t r;
    r = '{cs_n: cs, sclk: sk, mosi: mo, mcare: mc, busy: 1'b1, done: 1'b0};
    q.push_back(r);
  endtask

  task automatic build_pass(int start, int len);
    logic chained = 1'b0;
    for (int i = 0; i < len; i++) begin
      int idx = (start + i) % NB;
      logic [15:0] t = m_tx[idx];
      if (!chained)
        for (int k = 0; k < H; k++) push(1'b0, 1'b0, t[15], 1'b1);
      for (int b = 0; b < WD; b++) begin
        for (int k = 0; k < H; k++) push(1'b0, 1'b0, t[15 - b], 1'b1);
        for (int k = 0; k < H; k++) push(1'b0, 1'b1, t[15 - b], 1'b1);
      end
      for (int k = 0; k < H; k++) push(1'b0, 1'b0, 1'b0, 1'b0);
      m_rx[idx] = slave_word(m_fno);
      m_fno++;
      if (i != len - 1 && m_hold[idx]) begin
        chained = 1'b1;
      end else begin
        chained = 1'b0;
        for (int k = 0; k < (m_dly[idx] ? G : 1); k++) push(1'b1, 1'b0, 1'b0, 1'b0);
      end
    end
  endtask

  // reference model: advances one cycle per rising edge
  initial begin
    for (int i = 0; i < NB; i++) begin
      m_tx[i] = '0; m_hold[i] = 0; m_lock[i] = 0; m_dly[i] = 0; m_rx[i] = '0;
    end
    cur = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0, mcare: 1'b0, busy: 1'b0, done: 1'b0};
    forever begin
      @(posedge clk);
      if (rst_n) begin
        if (!cur.busy && trig && cfg_len != 0) begin
          build_pass(int'(cfg_start), int'(cfg_len));
          m_done = 1'b1;
        end
        if (wr_en && !(cur.busy && m_lock[wr_idx])) begin
          m_tx[wr_idx]   = wr_data;
          m_hold[wr_idx] = wr_ctrl[2];
          m_lock[wr_idx] = wr_ctrl[1];
          m_dly[wr_idx]  = wr_ctrl[0];
        end
        if (q.size() > 0) cur = q.pop_front();
        else cur = '{cs_n: 1'b1, sclk: 1'b0, mosi: 1'b0, mcare: 1'b0, busy: 1'b0, done: m_done};
      end
    end
  end

  task automatic check1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        check1("R4 R5 R6 cs_n", spi_cs_n, cur.cs_n);
        check1("R4 sclk", spi_sclk, cur.sclk);
        if (cur.mcare) check1("R3 R4 R10 R11 mosi", spi_mosi, cur.mosi);
        check1("R1 R2 R9 busy", busy, cur.busy);
        check1("R8 R9 done", done, cur.done);
      end
    end
  end

  task automatic wbuf(int idx, logic [15:0] d, logic hold, logic lock, logic dly);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d; wr_ctrl = {hold, lock, dly};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go(int start, int len);
    @(negedge clk);
    cfg_start = 3'(start); cfg_len = 4'(len); trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic chk_rx(int idx, string tag);
    @(negedge clk);
    rd_idx = 3'(idx);
    #1;
    n_chk++;
    if (rd_data !== m_rx[idx]) begin
      n_fail++;
      $display("FAIL %s rx[%0d]: actual %h expected %h", tag, idx, rd_data, m_rx[idx]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state of the receive fields
        for (int i = 0; i < NB; i++) chk_rx(i, "R12");
        for (int i = 0; i < NB; i++) wbuf(i, 16'((i * 16'h1357) ^ 16'hA5C3), 1'b0, 1'b0, 1'b1);
        // R1 R3 R7: basic pass 0..3
        go(0, 4); wait_idle();
        for (int i = 0; i < 4; i++) chk_rx(i, "R7");
        // R10: resend without rewrite
        go(0, 4); wait_idle();
        for (int i = 0; i < 4; i++) chk_rx(i, "R10");
        // R2: retrigger in the middle of a pass
        go(0, 4);
        repeat (40) @(negedge clk);
        go(2, 1);
        wait_idle();
        chk_rx(3, "R2");
        // R5 R6: chained frames, last buffer with hold set still releases
        wbuf(2, 16'h8001, 1'b1, 1'b0, 1'b0);
        wbuf(3, 16'h7FFE, 1'b1, 1'b0, 1'b1);
        wbuf(4, 16'hF00F, 1'b1, 1'b0, 1'b1);
        go(2, 3); wait_idle();
        for (int i = 2; i < 5; i++) chk_rx(i, "R5");
        // R3: wrap around, short gap on buffer 6
        wbuf(6, 16'h3C3C, 1'b0, 1'b0, 1'b0);
        go(6, 4); wait_idle();
        chk_rx(6, "R3"); chk_rx(7, "R3"); chk_rx(0, "R3"); chk_rx(1, "R3");
        // R9: zero length
        go(3, 0);
        repeat (10) @(negedge clk);
        // R11: lock protects buffer 5 during a pass, buffer 0 is writable
        wbuf(5, 16'h1234, 1'b0, 1'b1, 1'b1);
        go(4, 2);
        repeat (20) @(negedge clk);
        wbuf(5, 16'hDEAD, 1'b0, 1'b0, 1'b1);
        wbuf(0, 16'hBEEF, 1'b0, 1'b0, 1'b1);
        wait_idle();
        go(5, 1); wait_idle();
        go(0, 1); wait_idle();
        chk_rx(5, "R11"); chk_rx(0, "R11");
        // R10: rewrite between passes
        wbuf(1, 16'h0F0F, 1'b0, 1'b0, 1'b1);
        go(1, 1); wait_idle();
        chk_rx(1, "R10");
        // R2 R8: trigger held across the end of a pass
        @(negedge clk);
        cfg_start = 3'd0; cfg_len = 4'd2; trig = 1'b1;
        repeat (200) @(negedge clk);
        trig = 1'b0;
        wait_idle();
        for (int i = 0; i < NB; i++) chk_rx(i, "R7");
        repeat (5) @(negedge clk);
      end
      begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule